// File: doc/BRIEF.md
# Flash Command Register Controller

This block is the command front end of a byte-wide electrically erasable memory, modelled synchronously. The asynchronous chip-enable, write-enable and output-enable strobes are brought into the system clock domain by two-flop synchronisers. Falling and rising write-enable edges that occur while chip-enable is low are treated as bus write cycles. Each write carries a command byte. The controller keeps a mode register and, from the sequence of command bytes, produces one-cycle start and stop pulses for erase and program operations. It also latches the operand address and data, and tells the read path which source to use: the array at the live address, one of the two identification codes, or the array at the latched address under margin conditions.

Commands are accepted only while the high programming supply is flagged present. When the flag drops, the block falls back to read mode and ends any running operation. Several commands take two bus cycles: erase needs the byte 20h twice, program takes the byte 40h followed by an address and data write, and reset needs FFh twice. An internal stop timer ends any erase or program that no verify command has closed within a set number of clock cycles.

All ports are plain control and data levels. No port carries a stream, so the block has no valid/ready handshake and no back-pressure. The memory array and the two identification codes (20h and F4h) sit outside the block, selected by `rd_sel`.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (read), `rd_sel` is 0 (array at live address), `dq_oe` is 0, and no start or stop pulse is given.
- R2: While `vpp_ok` is low, command writes are ignored and `mode` stays 0.
- R3: When `vpp_ok` falls, `mode` returns to 0 and a running operation receives one stop pulse of its kind.
- R4: A write cycle needs `ce_n` low across a `we_n` low pulse. The address is taken when `we_n` falls and the data when `we_n` rises. A `we_n` pulse with `ce_n` high changes nothing.
- R5: Byte 80h or 90h gives `mode` 1 (signature). In this mode, `rd_sel` is 1 (maker code) when `addr[0]` is 0 and 2 (device code) when `addr[0]` is 1.
- R6: Byte 20h gives `mode` 2 (erase armed). A second 20h gives `mode` 3 (erasing) with exactly one `erase_start` pulse.
- R7: Byte A0h gives `mode` 4 (erase verify) and copies that cycle's address into `op_addr`. It gives one `erase_stop` pulse if an erase is running. `rd_sel` is 3 (margin read at `op_addr`) in modes 4 and 7.
- R8: Byte 40h gives `mode` 5 (program armed). The next write gives `mode` 6 (programming), copies its address and data into `op_addr` and `op_data`, and gives one `prog_start` pulse.
- R9: Byte C0h gives `mode` 7 (program verify) and gives one `prog_stop` pulse if a program is running. `op_addr` is kept.
- R10: A first FFh gives `mode` 8 with no stop pulse. A second consecutive FFh gives `mode` 0 and one stop pulse for any running operation.
- R11: An operation still running `STOP_CYCLES` cycles after its start pulse gets one stop pulse and `mode` 9 (halted). A later verify command is accepted normally.
- R12: Any byte that is not a command listed here gives `mode` 0.
- R13: A start request (second 20h, or the write after 40h) made while an operation runs gives no start pulse, and `mode` becomes 0.
- R14: `dq_oe` is 1 only when the synchronised `ce_n` and `oe_n` are low and `we_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vpp_ok | input | 1 | High programming supply present |
| ce_n | input | 1 | Chip enable strobe, asynchronous, active low |
| we_n | input | 1 | Write enable strobe, asynchronous, active low |
| oe_n | input | 1 | Output enable strobe, asynchronous, active low |
| addr | input | ADDR_W | Byte address from the bus |
| din | input | 8 | Command or data byte from the bus |
| mode | output | 4 | Current operating mode code |
| erase_start | output | 1 | One-cycle pulse starting erasure |
| erase_stop | output | 1 | One-cycle pulse stopping erasure |
| prog_start | output | 1 | One-cycle pulse starting programming |
| prog_stop | output | 1 | One-cycle pulse stopping programming |
| op_addr | output | ADDR_W | Latched operand address |
| op_data | output | 8 | Latched program data |
| rd_sel | output | 2 | Read source: 0 array, 1 maker code, 2 device code, 3 margin array at op_addr |
| dq_oe | output | 1 | Drive the data bus |

## Verification
The command sequences are driven as full strobe-level bus cycles: single-cycle commands, two-cycle starts followed by a verify, a double reset, and a start attempted while an operation already runs. Each sequence shows whether the mode register follows the two-cycle rules and whether start and stop pulses appear exactly once. Write cycles with `ce_n` high, writes with the supply flag low, and unknown bytes show which writes the block ignores or treats as a return to read. One write changes the address in the middle of the `we_n` pulse, which shows whether the address is taken at the falling edge. A long wait after a start that is never verified, compared against a shorter wait, tells the stop timer apart from the verify path.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [3:0] {
    MD_READ        = 4'd0,
    MD_SIG         = 4'd1,
    MD_ERASE_ARM   = 4'd2,
    MD_ERASING     = 4'd3,
    MD_ERASE_VFY   = 4'd4,
    MD_PROG_ARM    = 4'd5,
    MD_PROGRAMMING = 4'd6,
    MD_PROG_VFY    = 4'd7,
    MD_RESET_ARM   = 4'd8,
    MD_HALTED      = 4'd9
  } mode_e;

  typedef enum logic [1:0] {
    RS_ARRAY  = 2'd0,
    RS_MAKER  = 2'd1,
    RS_DEVICE = 2'd2,
    RS_MARGIN = 2'd3
  } rdsel_e;

  localparam logic [7:0] CMD_READ      = 8'h00;
  localparam logic [7:0] CMD_SIG_A     = 8'h80;
  localparam logic [7:0] CMD_SIG_B     = 8'h90;
  localparam logic [7:0] CMD_ERASE     = 8'h20;
  localparam logic [7:0] CMD_ERASE_VFY = 8'hA0;
  localparam logic [7:0] CMD_PROG      = 8'h40;
  localparam logic [7:0] CMD_PROG_VFY  = 8'hC0;
  localparam logic [7:0] CMD_RESET     = 8'hFF;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl
);
  // Strobes are active low, so every stage resets to the inactive level.
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-2:0], raw[i]};
    end
    assign lvl[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/op_timer.sv
module op_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == W'(LIMIT - 1));

  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < W'(LIMIT));
endmodule

// File: rtl/cmd_fsm.sv
module cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vpp_ok,
  input  logic              ce_low,
  input  logic              we_lvl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              tmo,
  output mode_e             mode_q,
  output logic              busy_q,
  output logic              erase_start,
  output logic              erase_stop,
  output logic              prog_start,
  output logic              prog_stop,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);
  logic              we_prev, busy_prog_q;
  logic              wr_fall, wr_rise;
  logic [ADDR_W-1:0] addr_cap;
  mode_e             n_mode;
  logic              st_e, st_p, stop_req, lat_a, lat_d;

  assign wr_fall = ce_low & we_prev & ~we_lvl;
  assign wr_rise = ce_low & ~we_prev & we_lvl;

  always_comb begin
    n_mode = mode_q; st_e = 1'b0; st_p = 1'b0;
    stop_req = 1'b0; lat_a = 1'b0; lat_d = 1'b0;
    if (!vpp_ok) begin
      n_mode   = MD_READ;
      stop_req = busy_q;
    end else if (tmo) begin
      n_mode   = MD_HALTED;
      stop_req = 1'b1;
    end else if (wr_rise) begin
      if (mode_q == MD_PROG_ARM) begin
        if (busy_q) n_mode = MD_READ;
        else begin
          n_mode = MD_PROGRAMMING; st_p = 1'b1; lat_a = 1'b1; lat_d = 1'b1;
        end
      end else if (mode_q == MD_ERASE_ARM && din == CMD_ERASE) begin
        if (busy_q) n_mode = MD_READ;
        else begin
          n_mode = MD_ERASING; st_e = 1'b1;
        end
      end else if (mode_q == MD_RESET_ARM && din == CMD_RESET) begin
        n_mode   = MD_READ;
        stop_req = busy_q;
      end else begin
        case (din)
          CMD_READ:             n_mode = MD_READ;
          CMD_SIG_A, CMD_SIG_B: n_mode = MD_SIG;
          CMD_ERASE:            n_mode = MD_ERASE_ARM;
          CMD_ERASE_VFY: begin
            n_mode = MD_ERASE_VFY; lat_a = 1'b1;
            stop_req = busy_q & ~busy_prog_q;
          end
          CMD_PROG:             n_mode = MD_PROG_ARM;
          CMD_PROG_VFY: begin
            n_mode = MD_PROG_VFY;
            stop_req = busy_q & busy_prog_q;
          end
          CMD_RESET:            n_mode = MD_RESET_ARM;
          default:              n_mode = MD_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_READ; busy_q <= 1'b0; busy_prog_q <= 1'b0; we_prev <= 1'b1;
      addr_cap <= '0; op_addr <= '0; op_data <= '0;
      erase_start <= 1'b0; erase_stop <= 1'b0;
      prog_start <= 1'b0; prog_stop <= 1'b0;
    end else begin
      we_prev     <= we_lvl;
      mode_q      <= n_mode;
      erase_start <= st_e;
      prog_start  <= st_p;
      erase_stop  <= stop_req & ~busy_prog_q;
      prog_stop   <= stop_req & busy_prog_q;
      if (wr_fall) addr_cap <= addr;
      if (lat_a)   op_addr  <= addr_cap;
      if (lat_d)   op_data  <= din;
      if (st_e || st_p) begin
        busy_q <= 1'b1; busy_prog_q <= st_p;
      end else if (stop_req) begin
        busy_q <= 1'b0;
      end
    end
  end

  p_no_cmd_without_vpp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_ok |=> mode_q == MD_READ);
  p_erase_start_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> mode_q == MD_ERASING && busy_q);
  p_prog_start_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> mode_q == MD_PROGRAMMING && busy_q);
  p_one_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_start, erase_stop, prog_start, prog_stop}));
  p_stop_clears_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_stop || prog_stop) |-> !busy_q);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int STOP_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vpp_ok,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [3:0]        mode,
  output logic              erase_start,
  output logic              erase_stop,
  output logic              prog_start,
  output logic              prog_stop,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic [1:0]        rd_sel,
  output logic              dq_oe
);
  logic [2:0] lvl;
  logic       ce_low, tmo, busy;
  mode_e      mode_q;
  rdsel_e     sel;

  strobe_sync #(.N(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({oe_n, we_n, ce_n}), .lvl(lvl)
  );

  assign ce_low = ~lvl[0];

  op_timer #(.LIMIT(STOP_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .expired(tmo)
  );

  cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .vpp_ok(vpp_ok), .ce_low(ce_low), .we_lvl(lvl[1]),
    .addr(addr), .din(din), .tmo(tmo), .mode_q(mode_q), .busy_q(busy),
    .erase_start(erase_start), .erase_stop(erase_stop),
    .prog_start(prog_start), .prog_stop(prog_stop),
    .op_addr(op_addr), .op_data(op_data)
  );

  always_comb begin
    case (mode_q)
      MD_SIG:                    sel = addr[0] ? RS_DEVICE : RS_MAKER;
      MD_ERASE_VFY, MD_PROG_VFY: sel = RS_MARGIN;
      default:                   sel = RS_ARRAY;
    endcase
  end

  assign mode   = mode_q;
  assign rd_sel = sel;
  assign dq_oe  = ce_low & ~lvl[2] & lvl[1];

  p_timeout_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && vpp_ok) |=> !busy && mode == 4'd9);
  p_verify_margin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd4 || mode == 4'd7) |-> rd_sel == 2'd3);
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int AW   = 18;
  localparam int STOP = 200;

  logic clk = 1'b0, rst_n = 1'b0, vpp_ok = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [3:0] mode;
  logic es, ep, ps, pp, dq_oe;
  logic [AW-1:0] op_addr;
  logic [7:0] op_data;
  logic [1:0] rd_sel;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int c_es = 0, c_ep = 0, c_ps = 0, c_pp = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .STOP_CYCLES(STOP)) u_dut (
    .clk(clk), .rst_n(rst_n), .vpp_ok(vpp_ok), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .mode(mode), .erase_start(es), .erase_stop(ep),
    .prog_start(ps), .prog_stop(pp), .op_addr(op_addr), .op_data(op_data),
    .rd_sel(rd_sel), .dq_oe(dq_oe)
  );

  always @(negedge clk) if (rst_n) begin
    if (es) c_es++;
    if (ep) c_ep++;
    if (ps) c_ps++;
    if (pp) c_pp++;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write2(input logic [AW-1:0] a_fall, input logic [AW-1:0] a_rise,
                            input logic [7:0] d, input logic ce_val);
    addr = a_fall; din = d; ce_n = ce_val;
    wait_cyc(2);
    we_n = 1'b0;
    wait_cyc(4);
    addr = a_rise;
    wait_cyc(1);
    we_n = 1'b1;
    wait_cyc(4);
    ce_n = 1'b1;
    wait_cyc(2);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
    bus_write2(a, a, d, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 mode", mode, 0);
    chk("R1 rd_sel", rd_sel, 0);
    chk("R1 dq_oe", dq_oe, 0);
    chk("R1 pulses", c_es + c_ep + c_ps + c_pp, 0);
  endtask

  task automatic t_output_enable;
    ce_n = 0; oe_n = 0; wait_cyc(4);
    chk("R14 ce+oe low", dq_oe, 1);
    oe_n = 1; wait_cyc(4);
    chk("R14 oe high", dq_oe, 0);
    oe_n = 0; ce_n = 1; wait_cyc(4);
    chk("R14 ce high", dq_oe, 0);
    oe_n = 1; wait_cyc(2);
  endtask

  task automatic t_no_vpp;
    bus_write('0, 8'h40);
    chk("R2 mode after 40h", mode, 0);
    bus_write('0, 8'h20);
    bus_write('0, 8'h20);
    chk("R2 no erase start", c_es, 0);
  endtask

  task automatic t_signature;
    bus_write('0, 8'h90);
    chk("R5 mode 90h", mode, 1);
    addr = 18'h0; wait_cyc(1);
    chk("R5 maker sel", rd_sel, 1);
    addr = 18'h1; wait_cyc(1);
    chk("R5 device sel", rd_sel, 2);
    bus_write('0, 8'h00);
    bus_write('0, 8'h80);
    chk("R5 mode 80h", mode, 1);
    bus_write2('0, '0, 8'h00, 1'b1);
    chk("R4 ce high write ignored", mode, 1);
  endtask

  task automatic t_unknown;
    bus_write('0, 8'h55);
    chk("R12 unknown byte", mode, 0);
    chk("R12 rd_sel array", rd_sel, 0);
  endtask

  task automatic t_erase;
    bus_write('0, 8'h20);
    chk("R6 armed", mode, 2);
    chk("R6 no start yet", c_es, 0);
    bus_write('0, 8'h20);
    chk("R6 erasing", mode, 3);
    chk("R6 one start", c_es, 1);
    bus_write(18'h155, 8'hA0);
    chk("R7 verify mode", mode, 4);
    chk("R7 one stop", c_ep, 1);
    chk("R7 op_addr", op_addr, 18'h155);
    chk("R7 margin sel", rd_sel, 3);
  endtask

  task automatic t_program;
    bus_write('0, 8'h40);
    chk("R8 armed", mode, 5);
    bus_write2(18'h2A5A, 18'h0F0F, 8'h3C, 1'b0);
    chk("R8 programming", mode, 6);
    chk("R8 one start", c_ps, 1);
    chk("R4 addr at we fall", op_addr, 18'h2A5A);
    chk("R8 op_data", op_data, 8'h3C);
    bus_write(18'h0033, 8'hC0);
    chk("R9 verify mode", mode, 7);
    chk("R9 one stop", c_pp, 1);
    chk("R9 op_addr kept", op_addr, 18'h2A5A);
    chk("R7 margin sel in pv", rd_sel, 3);
  endtask

  task automatic t_reset_cmd;
    bus_write('0, 8'h40);
    bus_write(18'h10, 8'h77);
    chk("R10 programming", c_ps, 2);
    bus_write('0, 8'hFF);
    chk("R10 first FF mode", mode, 8);
    chk("R10 no stop yet", c_pp, 1);
    bus_write('0, 8'hFF);
    chk("R10 second FF mode", mode, 0);
    chk("R10 abort stop", c_pp, 2);
  endtask

  task automatic t_start_while_busy;
    bus_write('0, 8'h20);
    bus_write('0, 8'h20);
    chk("R13 erase running", c_es, 2);
    bus_write('0, 8'h40);
    bus_write(18'h1234, 8'hAA);
    chk("R13 mode to read", mode, 0);
    chk("R13 no prog start", c_ps, 2);
    bus_write(18'h7, 8'hA0);
    chk("R13 erase still stoppable", c_ep, 2);
  endtask

  task automatic t_timeout;
    bus_write('0, 8'h20);
    bus_write('0, 8'h20);
    chk("R11 erase started", c_es, 3);
    wait_cyc(STOP - 60);
    chk("R11 not yet stopped", c_ep, 2);
    chk("R11 still erasing", mode, 3);
    wait_cyc(80);
    chk("R11 timer stop", c_ep, 3);
    chk("R11 halted", mode, 9);
    bus_write(18'h9, 8'hA0);
    chk("R11 verify after halt", mode, 4);
    chk("R11 no extra stop", c_ep, 3);
  endtask

  task automatic t_vpp_drop;
    bus_write('0, 8'h40);
    bus_write(18'h20, 8'h11);
    chk("R3 programming", mode, 6);
    vpp_ok = 0; wait_cyc(3);
    chk("R3 mode read", mode, 0);
    chk("R3 stop pulse", c_pp, 3);
    vpp_ok = 1; wait_cyc(2);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(3);
    t_reset();
    t_output_enable();
    t_no_vpp();
    vpp_ok = 1; wait_cyc(2);
    t_signature();
    t_unknown();
    t_erase();
    t_program();
    t_reset_cmd();
    t_start_while_busy();
    t_timeout();
    t_vpp_drop();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule